// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block frames every transfer of an SPI-style master with up to eight chip-select lines and a fixed sequence of delays. A write to the transmit buffer opens a select period. The enabled lines go to their programmed active level and a lead delay runs. The block then pulses a start strobe to the serial shifter and waits for the shifter's done strobe. After that it holds the selects for a trail delay, releases them, and waits out an inactive gap before any further frame may begin.

Software programs three registers through a single-cycle write port: line configuration, delay timing and the transmit buffer. Delays are counted in serial-clock periods, which arrive as one-cycle `sclkTick` pulses from an external baud generator. The timing, the data and the line configuration are captured when the transmit buffer is written. A write that arrives while a frame is still running is held, and it starts the next frame as soon as the inactive gap ends.

Top module: `spi_csel_seq`

## Requirements
- R1: After reset `busy` and `shiftStart` are 0, all line enables and polarities are 0, and `selOut` is 8'hFF (every line at its inactive level).
- R2: A write to address 2 while idle makes `busy` 1 and drives the enabled lines to their active level in the following cycle.
- R3: Configuration bit `pol[i]` set to 1 makes line i active-high and 0 makes it active-low. An enabled line shows its active level only during the lead, frame and trail phases. A disabled line stays at `~pol[i]` at all times.
- R4: The lead phase lasts lead+1 serial-clock ticks. `shiftStart` is then a single-cycle pulse in the first frame cycle, with `shiftData` equal to the byte that was written.
- R5: The frame phase lasts until `shiftDone`. Trail then lasts trail+1 ticks, after which the lines return to their inactive level.
- R6: The inactive phase lasts inact+1 ticks with the lines inactive. `busy` then falls, unless a held write is waiting.
- R7: Lead, trail and inact are taken from the timing register as it stood at the transmit-buffer write. A timing write made after that point does not change the frame.
- R8: A transmit-buffer write made while `busy` is held. When the inactive phase ends, a new lead phase starts at once and `busy` does not drop.
- R9: Register map: address 0 holds {pol[15:8], en[7:0]}; address 1 holds {inact[5:4], trail[3:2], lead[1:0]}; address 2 is the transmit buffer with data in [7:0]. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| sclkTick | input | 1 | One-cycle pulse per serial-clock period |
| shiftDone | input | 1 | Shifter finished the last bit |
| shiftStart | output | 1 | Start pulse to the shifter |
| shiftData | output | 8 | Frame data for the shifter |
| selOut | output | 8 | Chip-select lines |
| busy | output | 1 | Select period or inactive gap in progress |

## Verification
The assertions assume that the shifter raises `shiftDone` only during the frame phase, as one single-cycle pulse per `shiftStart`. They also assume that `sclkTick` is never held high for two cycles in a row. The bench keeps to this: it raises done once, four cycles after it sees the start pulse, and it generates ticks every fourth cycle. Held writes are issued only during trail or inactive, so at most one write is ever waiting.

// File: rtl/spi_csel_pkg.sv
package spi_csel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_FRAME,
    ST_TRAIL,
    ST_INACT
  } seq_state_e;

  typedef enum logic [1:0] {
    CNT_LEAD,
    CNT_TRAIL,
    CNT_INACT
  } cnt_src_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic     loadAct;  // capture frame setup, counter <- lead
    logic     loadCnt;  // counter <- trail or inact
    cnt_src_e cntSrc;
    logic     decCnt;
    logic     selOn;    // select period active
  } seq_strobe_t;

  localparam int ADDR_CFG  = 0;
  localparam int ADDR_TIME = 1;
  localparam int ADDR_TXB  = 2;

endpackage

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl
  import spi_csel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tbWr,
  input  logic        sclkTick,
  input  logic        shiftDone,
  input  logic        cntZero,
  output seq_strobe_t strb,
  output logic        shiftStart,
  output logic        busy
);

  seq_state_e state, stateNext;
  logic       pending;
  logic       startQ;

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.cntSrc = CNT_LEAD;
    unique case (state)
      ST_IDLE: begin
        if (tbWr) begin
          stateNext    = ST_LEAD;
          strb.loadAct = 1'b1;
        end
      end
      ST_LEAD: begin
        strb.selOn = 1'b1;
        if (sclkTick) begin
          if (cntZero) stateNext   = ST_FRAME;
          else         strb.decCnt = 1'b1;
        end
      end
      ST_FRAME: begin
        strb.selOn = 1'b1;
        if (shiftDone) begin
          stateNext    = ST_TRAIL;
          strb.loadCnt = 1'b1;
          strb.cntSrc  = CNT_TRAIL;
        end
      end
      ST_TRAIL: begin
        strb.selOn = 1'b1;
        if (sclkTick) begin
          if (cntZero) begin
            stateNext    = ST_INACT;
            strb.loadCnt = 1'b1;
            strb.cntSrc  = CNT_INACT;
          end else begin
            strb.decCnt = 1'b1;
          end
        end
      end
      ST_INACT: begin
        if (sclkTick) begin
          if (cntZero) begin
            if (pending || tbWr) begin
              stateNext    = ST_LEAD;
              strb.loadAct = 1'b1;
            end else begin
              stateNext = ST_IDLE;
            end
          end else begin
            strb.decCnt = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      startQ  <= 1'b0;
    end else begin
      state  <= stateNext;
      startQ <= (state == ST_LEAD) && sclkTick && cntZero;
      if (strb.loadAct)                     pending <= 1'b0;
      else if (tbWr && (state != ST_IDLE))  pending <= 1'b1;
    end
  end

  assign shiftStart = startQ;
  assign busy       = (state != ST_IDLE);

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && tbWr) |=> (state == ST_LEAD && busy));

  // R4
  lead_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEAD && sclkTick && cntZero) |=> (shiftStart && state == ST_FRAME));

  // R5
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRAME && !shiftDone) |=> (state == ST_FRAME && !shiftStart));

  // R8
  pend_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INACT && sclkTick && cntZero && pending) |=> (state == ST_LEAD && !pending));

endmodule

// File: rtl/spi_csel_dp.sv
module spi_csel_dp
  import spi_csel_pkg::*;
#(
  parameter int NSEL = 8,
  parameter int DW   = 8,
  parameter int DLYW = 2,
  parameter int AW   = 2,
  parameter int WW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [AW-1:0]   regAddr,
  input  logic [WW-1:0]   regWrData,
  input  seq_strobe_t     strb,
  output logic            tbWr,
  output logic            cntZero,
  output logic [NSEL-1:0] selOut,
  output logic [DW-1:0]   shiftData
);

  localparam logic [AW-1:0] A_CFG  = AW'(ADDR_CFG);
  localparam logic [AW-1:0] A_TIME = AW'(ADDR_TIME);
  localparam logic [AW-1:0] A_TXB  = AW'(ADDR_TXB);

  // live registers
  logic [NSEL-1:0] cfgEn, cfgPol;
  logic [DLYW-1:0] cfgLead, cfgTrail, cfgInact;
  // captured at transmit write, waiting to start
  logic [NSEL-1:0] stEn, stPol;
  logic [DLYW-1:0] stLead, stTrail, stInact;
  logic [DW-1:0]   stData;
  // owned by the running frame
  logic [NSEL-1:0] actEn, actPol;
  logic [DLYW-1:0] actTrail, actInact;
  logic [DW-1:0]   actData;
  logic [DLYW-1:0] cnt;

  logic [NSEL-1:0] srcEn, srcPol;
  logic [DLYW-1:0] srcLead, srcTrail, srcInact;
  logic [DW-1:0]   srcData;

  assign tbWr = regWrEn && (regAddr == A_TXB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEn    <= '0;
      cfgPol   <= '0;
      cfgLead  <= '0;
      cfgTrail <= '0;
      cfgInact <= '0;
    end else if (regWrEn) begin
      if (regAddr == A_CFG) begin
        cfgEn  <= regWrData[NSEL-1:0];
        cfgPol <= regWrData[2*NSEL-1:NSEL];
      end
      if (regAddr == A_TIME) begin
        cfgLead  <= regWrData[DLYW-1:0];
        cfgTrail <= regWrData[2*DLYW-1:DLYW];
        cfgInact <= regWrData[3*DLYW-1:2*DLYW];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stEn    <= '0;
      stPol   <= '0;
      stLead  <= '0;
      stTrail <= '0;
      stInact <= '0;
      stData  <= '0;
    end else if (tbWr) begin
      stEn    <= cfgEn;
      stPol   <= cfgPol;
      stLead  <= cfgLead;
      stTrail <= cfgTrail;
      stInact <= cfgInact;
      stData  <= regWrData[DW-1:0];
    end
  end

  // a write in the starting cycle bypasses the staging copy
  always_comb begin
    if (tbWr) begin
      srcEn    = cfgEn;
      srcPol   = cfgPol;
      srcLead  = cfgLead;
      srcTrail = cfgTrail;
      srcInact = cfgInact;
      srcData  = regWrData[DW-1:0];
    end else begin
      srcEn    = stEn;
      srcPol   = stPol;
      srcLead  = stLead;
      srcTrail = stTrail;
      srcInact = stInact;
      srcData  = stData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actEn    <= '0;
      actPol   <= '0;
      actTrail <= '0;
      actInact <= '0;
      actData  <= '0;
      cnt      <= '0;
    end else begin
      if (strb.loadAct) begin
        actEn    <= srcEn;
        actPol   <= srcPol;
        actTrail <= srcTrail;
        actInact <= srcInact;
        actData  <= srcData;
        cnt      <= srcLead;
      end else if (strb.loadCnt) begin
        cnt <= (strb.cntSrc == CNT_TRAIL) ? actTrail : actInact;
      end else if (strb.decCnt) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cntZero   = (cnt == '0);
  assign shiftData = actData;

  for (genvar i = 0; i < NSEL; i++) begin : g_line
    always_comb begin
      if (strb.selOn) selOut[i] = actEn[i] ? actPol[i] : ~actPol[i];
      else            selOut[i] = ~cfgPol[i];
    end
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCnt |-> (cnt != '0));

  // R7
  frame_setup_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selOn && $past(strb.selOn) && !$past(strb.loadAct))
      |-> ($stable(actTrail) && $stable(actInact) && $stable(actEn) && $stable(actPol)));

endmodule

// File: rtl/spi_csel_seq.sv
module spi_csel_seq
  import spi_csel_pkg::*;
#(
  parameter int NSEL = 8,
  parameter int DW   = 8,
  parameter int DLYW = 2,
  parameter int AW   = 2,
  parameter int WW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [AW-1:0]   regAddr,
  input  logic [WW-1:0]   regWrData,
  input  logic            sclkTick,
  input  logic            shiftDone,
  output logic            shiftStart,
  output logic [DW-1:0]   shiftData,
  output logic [NSEL-1:0] selOut,
  output logic            busy
);

  seq_strobe_t strb;
  logic        tbWr;
  logic        cntZero;

  spi_csel_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tbWr      (tbWr),
    .sclkTick  (sclkTick),
    .shiftDone (shiftDone),
    .cntZero   (cntZero),
    .strb      (strb),
    .shiftStart(shiftStart),
    .busy      (busy)
  );

  spi_csel_dp #(
    .NSEL(NSEL), .DW(DW), .DLYW(DLYW), .AW(AW), .WW(WW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb),
    .tbWr     (tbWr),
    .cntZero  (cntZero),
    .selOut   (selOut),
    .shiftData(shiftData)
  );

endmodule

// File: tb/spi_csel_seq_tb.sv
`timescale 1ns/1ps
module spi_csel_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        sclkTick = 1'b0;
  logic        shiftDone = 1'b0;
  logic        shiftStart;
  logic [7:0]  shiftData;
  logic [7:0]  selOut;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;
  int cycCnt  = 0;

  always #2 clk = ~clk;

  spi_csel_seq u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .sclkTick(sclkTick), .shiftDone(shiftDone),
    .shiftStart(shiftStart), .shiftData(shiftData), .selOut(selOut), .busy(busy)
  );

  // {en[29:22], pol[21:14], lead[13:12], trail[11:10], inact[9:8], data[7:0]}
  localparam logic [29:0] VEC [6] = '{
    {8'hFF, 8'h00, 2'd0, 2'd0, 2'd0, 8'hA5},
    {8'h01, 8'h01, 2'd3, 2'd3, 2'd3, 8'h3C},
    {8'h0F, 8'hF0, 2'd1, 2'd2, 2'd0, 8'h81},
    {8'hA0, 8'h20, 2'd2, 2'd0, 2'd1, 8'h7E},
    {8'h81, 8'h80, 2'd0, 2'd3, 2'd2, 8'h00},
    {8'h3C, 8'hFF, 2'd1, 2'd1, 2'd3, 8'hFF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    sclkTick = 1'b0; shiftDone = 1'b0;
    cycCnt++;
  endtask

  task automatic idleStep();
    @(negedge clk);
    regWrEn = 1'b0; sclkTick = 1'b0; shiftDone = 1'b0;
    cycCnt++;
  endtask

  function automatic logic [15:0] timeWord(input logic [29:0] v);
    return {10'd0, v[9:8], v[11:10], v[13:12]};
  endfunction

  task automatic runFrame(input logic [29:0] v, input bit doWrite, input bit midTime,
                          input bit pendWrite, input logic [29:0] pv, output bit chained);
    logic [7:0] en, pol, expSel;
    int p, leadN, trailN, inactN, startN, patErr, frameCyc, pst, step;
    bit startSeen, doneSeen, inactSeen, sel, hung;
    en = v[29:22]; pol = v[21:14];
    p = 0;
    for (int i = 7; i >= 0; i--) if (en[i]) p = i;
    leadN = 0; trailN = 0; inactN = 0; startN = 0; patErr = 0;
    frameCyc = 0; pst = 0; step = 0; hung = 0;
    startSeen = 0; doneSeen = 0; inactSeen = 0; chained = 0;
    if (doWrite) begin
      regWrite(2'd0, {pol, en});
      regWrite(2'd1, timeWord(v));
      regWrite(2'd2, {8'h00, v[7:0]});
    end
    forever begin
      @(negedge clk);
      regWrEn = 1'b0; shiftDone = 1'b0;
      cycCnt++;
      sel = (selOut[p] == pol[p]);
      expSel = sel ? ~(en ^ pol) : ~pol;
      if (selOut !== expSel) patErr++;
      if (step == 0) chk(busy && sel, "R2 busy/select at start", {busy, sel}, 3);
      if (inactSeen && sel) begin chained = 1; sclkTick = 1'b0; break; end
      if (doneSeen && !busy) begin sclkTick = 1'b0; break; end
      if (step > 3000) begin hung = 1; sclkTick = 1'b0; break; end
      if (shiftStart) begin
        startSeen = 1; startN++;
        chk(shiftData == v[7:0], "R4 shiftData", shiftData, v[7:0]);
      end
      sclkTick = (cycCnt % 4 == 0);
      if (midTime && step == 0) begin
        regWrEn = 1'b1; regAddr = 2'd1; regWrData = ~timeWord(v) & 16'h003F;
      end
      if (pendWrite && doneSeen && pst < 3) begin
        regWrEn = 1'b1;
        if (pst == 0) begin regAddr = 2'd1; regWrData = timeWord(pv); end
        if (pst == 1) begin regAddr = 2'd2; regWrData = {8'h00, pv[7:0]}; end
        if (pst == 2) begin regAddr = 2'd1; regWrData = ~timeWord(pv) & 16'h003F; end
        pst++;
      end
      if (startSeen && !doneSeen) begin
        frameCyc++;
        if (frameCyc == 4) shiftDone = 1'b1;
      end
      if (sel && !startSeen && sclkTick) leadN++;
      if (sel && doneSeen && sclkTick) trailN++;
      if (!sel && busy && doneSeen) begin
        inactSeen = 1;
        if (sclkTick) inactN++;
      end
      if (shiftDone) doneSeen = 1;
      step++;
    end
    chk(!hung, "R5 frame completes", hung, 0);
    chk(leadN == int'(v[13:12]) + 1, "R4 lead ticks", leadN, int'(v[13:12]) + 1);
    chk(startN == 1, "R4 single start pulse", startN, 1);
    chk(trailN == int'(v[11:10]) + 1, "R5 trail ticks", trailN, int'(v[11:10]) + 1);
    chk(inactN == int'(v[9:8]) + 1, "R6 inactive ticks", inactN, int'(v[9:8]) + 1);
    chk(patErr == 0, "R3 select pattern", patErr, 0);
    if (!chained) chk(!busy && selOut == ~pol, "R6 idle after gap", {busy, selOut}, {1'b0, ~pol});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycCnt);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    bit ch;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleStep();
    // R1 reset state
    chk(selOut == 8'hFF, "R1 selOut reset", selOut, 8'hFF);
    chk(!busy && !shiftStart, "R1 busy/start reset", {busy, shiftStart}, 0);

    for (int k = 0; k < 6; k++) begin
      runFrame(VEC[k], 1'b1, 1'b0, 1'b0, '0, ch);
      repeat (3) idleStep();
    end

    // R7 timing write during lead does not alter running frame
    runFrame(VEC[1], 1'b1, 1'b1, 1'b0, '0, ch);
    repeat (2) idleStep();

    // R8 write during trail is held and chains without idle
    runFrame(VEC[2], 1'b1, 1'b0, 1'b1, {8'h0F, 8'hF0, 2'd2, 2'd1, 2'd2, 8'h5A}, ch);
    chk(ch, "R8 held write chained", ch, 1);
    // R7/R8 held frame uses timing captured at its write
    runFrame({8'h0F, 8'hF0, 2'd2, 2'd1, 2'd2, 8'h5A}, 1'b0, 1'b0, 1'b0, '0, ch);
    repeat (2) idleStep();

    // R9 write to unused address 3 has no effect
    regWrite(2'd3, 16'hFFFF);
    idleStep();
    chk(!busy && selOut == ~8'hF0, "R9 address 3 ignored", {busy, selOut}, {1'b0, ~8'hF0});
    repeat (4) idleStep();
    chk(!busy && !shiftStart, "R9 no frame from address 3", {busy, shiftStart}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule